// File: doc/BRIEF.md
# Multi-core inter-processor interrupt register bank

This block keeps a private set of interrupt registers for every core of a multi-core cluster. Each core's set is made of a pending-status word, an enable mask, write-only set and clear ports for the status, and a small mailbox of scratch words. Each core also has one interrupt line, which stays high while any enabled status bit is pending. All of these registers share a single 32-bit register port. The bank that an access reaches is not chosen by the address. It is chosen by the index of the requesting core, which arrives alongside the access. A core therefore always sees its own registers at the same offsets.

One offset is a send command. When a core writes it, a chosen vector is posted into another core's status word, exactly as if the target core had written a one-hot word to its own set port. A send that names a core which does not exist is refused with an error response and has no effect. Every request gets exactly one response in the following cycle. The response carries read data and an error flag.

Top module: `ipi_regs_top`

## Requirements
- R1: Only 4-byte requests (`reqSize` = 4) are accepted. Any other size gets an error response, returns zero data and changes no register.
- R2: Only `reqAddr[7:0]` is decoded, so offsets that differ only above bit 7 reach the same register.
- R3: A request acts on the bank of core `reqCore`. A request whose `reqCore` is at or above `NUM_CORES` gets an error response and changes nothing.
- R4: Status sits at offset 0x00 and is read-only. A write to offset 0x08 ORs the data into status. A write to offset 0x0C clears the status bits that are one in the data.
- R5: The enable mask at offset 0x04 is read/write. `irqOut[c]` is high exactly while core c has a bit set in both status and enable.
- R6: A write to the send offset 0x10 takes the target core from data bits 25:16 and the vector from bits 4:0. It sets status bit [vector] of the target's bank only. The sender's bank is left unchanged.
- R7: A send whose target is at or above `NUM_CORES` gets an error response and changes no state.
- R8: A write to an unimplemented or misaligned offset is ignored and completes without error. A read of such an offset, or of the set, clear or send offsets, returns zero without error.
- R9: The mailbox words sit at offsets 0x20 + 4*i for i below `MBOX_WORDS`. Each word reads back the value last written to it in the same bank.
- R10: Each request gets exactly one response (`rspValid`) in the cycle after it. No response appears without a request. Read data is zero for writes and for errors.
- R11: After reset, every status, enable and mailbox word is zero and every `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCore | input | 10 | Index of the requesting core |
| reqAddr | input | ADDR_W (12) | Register offset; only bits 7:0 are decoded |
| reqSize | input | 4 | Access size in bytes |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response present |
| rspErr | output | 1 | Decode or size error |
| rspRdata | output | 32 | Read data |
| irqOut | output | NUM_CORES (4) | Per-core interrupt line |

## Verification
Any corrupt status or enable bit shows up on that core's interrupt line in the same cycle the register updates. It also appears in the status or enable read data one cycle after a read. A send that is steered into the wrong bank raises the wrong core's line right after the write, and leaves the intended core's status reading zero. A mailbox word, or a bank selection that aliases across cores, only shows up when the word is read back. For that reason the bench reads mailbox contents from both the owning core and a different core.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;

  localparam int CORE_ID_W = 10;
  localparam int DATA_W    = 32;
  localparam int MB_IDX_W  = 6;

  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] OFF_SEND   = 8'h10;
  localparam logic [7:0] OFF_MBOX   = 8'h20;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_ENABLE,
    RD_MBOX
  } rdSel_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic                 enWr;
    logic                 setWr;
    logic                 clrWr;
    logic                 mbWr;
    logic [CORE_ID_W-1:0] bank;
    logic [MB_IDX_W-1:0]  mbIdx;
    logic [DATA_W-1:0]    wdata;
  } ipiStrobe_t;

endpackage

// File: rtl/ipi_ctrl.sv
`timescale 1ns/1ps
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int MBOX_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [CORE_ID_W-1:0] reqCore,
  input  logic [7:0]           reqOff,
  input  logic [3:0]           reqSize,
  input  logic [DATA_W-1:0]    reqWdata,
  output ipiStrobe_t           stb,
  output rdSel_e               rdSel,
  output logic [CORE_ID_W-1:0] rdBank,
  output logic [MB_IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0]    rdWord,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [DATA_W-1:0]    rspRdata
);

  localparam logic [CORE_ID_W:0] CORE_LIM = (CORE_ID_W+1)'(NUM_CORES);
  localparam int                 MBOX_END = 32 + 4 * MBOX_WORDS;

  logic                 sizeOk, coreOk, tgtOk, accOk;
  logic                 isSend, isMbox, reqBad;
  logic [CORE_ID_W-1:0] sendTgt;
  logic [7:0]           mbOff;

  assign sendTgt = reqWdata[25:16];
  assign sizeOk  = (reqSize == 4'd4);
  assign coreOk  = ({1'b0, reqCore} < CORE_LIM);
  assign tgtOk   = ({1'b0, sendTgt} < CORE_LIM);
  assign isSend  = (reqOff == OFF_SEND);
  assign mbOff   = reqOff - OFF_MBOX;
  assign isMbox  = (reqOff >= OFF_MBOX) && ({1'b0, reqOff} < 9'(MBOX_END))
                   && (reqOff[1:0] == 2'b00);
  assign accOk   = reqValid && sizeOk && coreOk;
  assign reqBad  = !sizeOk || !coreOk || (reqWrite && isSend && !tgtOk);

  // Write strobes
  always_comb begin
    stb       = '0;
    stb.bank  = reqCore;
    stb.mbIdx = mbOff[7:2];
    stb.wdata = reqWdata;
    if (accOk && reqWrite) begin
      unique case (1'b1)
        (reqOff == OFF_ENABLE): stb.enWr  = 1'b1;
        (reqOff == OFF_SET):    stb.setWr = 1'b1;
        (reqOff == OFF_CLEAR):  stb.clrWr = 1'b1;
        isSend: begin
          if (tgtOk) begin
            stb.setWr = 1'b1;
            stb.bank  = sendTgt;
            stb.wdata = DATA_W'(1) << reqWdata[4:0];
          end
        end
        isMbox:                 stb.mbWr  = 1'b1;
        default: ;
      endcase
    end
  end

  // Read selection
  always_comb begin
    rdBank = reqCore;
    rdIdx  = mbOff[7:2];
    rdSel  = RD_NONE;
    if (accOk && !reqWrite) begin
      if (reqOff == OFF_STATUS)      rdSel = RD_STATUS;
      else if (reqOff == OFF_ENABLE) rdSel = RD_ENABLE;
      else if (isMbox)               rdSel = RD_MBOX;
    end
  end

  // Registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && reqBad;
      rspRdata <= (rdSel != RD_NONE) ? rdWord : '0;
    end
  end

endmodule

// File: rtl/ipi_datapath.sv
`timescale 1ns/1ps
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int MBOX_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ipiStrobe_t           stb,
  input  rdSel_e               rdSel,
  input  logic [CORE_ID_W-1:0] rdBank,
  input  logic [MB_IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0]    rdWord,
  output logic [NUM_CORES-1:0] irqOut
);

  logic [NUM_CORES-1:0][DATA_W-1:0]                 statusAll;
  logic [NUM_CORES-1:0][DATA_W-1:0]                 enableAll;
  logic [NUM_CORES-1:0][MBOX_WORDS-1:0][DATA_W-1:0] mboxAll;

  for (genvar g = 0; g < NUM_CORES; g++) begin : gBank
    logic                              hit;
    logic [DATA_W-1:0]                 statusQ;
    logic [DATA_W-1:0]                 enableQ;
    logic [MBOX_WORDS-1:0][DATA_W-1:0] mboxQ;

    assign hit = (stb.bank == CORE_ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ <= '0;
        enableQ <= '0;
        mboxQ   <= '0;
      end else if (hit) begin
        if (stb.setWr)      statusQ <= statusQ | stb.wdata;
        else if (stb.clrWr) statusQ <= statusQ & ~stb.wdata;
        if (stb.enWr)       enableQ <= stb.wdata;
        for (int w = 0; w < MBOX_WORDS; w++) begin
          if (stb.mbWr && stb.mbIdx == MB_IDX_W'(w)) mboxQ[w] <= stb.wdata;
        end
      end
    end

    assign statusAll[g] = statusQ;
    assign enableAll[g] = enableQ;
    assign mboxAll[g]   = mboxQ;
    assign irqOut[g]    = |(statusQ & enableQ);
  end

  always_comb begin
    rdWord = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rdBank == CORE_ID_W'(c)) begin
        unique case (rdSel)
          RD_STATUS: rdWord = statusAll[c];
          RD_ENABLE: rdWord = enableAll[c];
          RD_MBOX: begin
            for (int w = 0; w < MBOX_WORDS; w++) begin
              if (rdIdx == MB_IDX_W'(w)) rdWord = mboxAll[c][w];
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ipi_regs_top.sv
`timescale 1ns/1ps
module ipi_regs_top
  import ipi_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int MBOX_WORDS = 8,
  parameter int ADDR_W     = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [9:0]           reqCore,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [3:0]           reqSize,
  input  logic [31:0]          reqWdata,
  output logic                 rspValid,
  output logic                 rspErr,
  output logic [31:0]          rspRdata,
  output logic [NUM_CORES-1:0] irqOut
);

  ipiStrobe_t           stb;
  rdSel_e               rdSel;
  logic [CORE_ID_W-1:0] rdBank;
  logic [MB_IDX_W-1:0]  rdIdx;
  logic [DATA_W-1:0]    rdWord;
  logic                 unusedAddrHi;

  // Offset bits above 7 are not decoded
  assign unusedAddrHi = ^reqAddr[ADDR_W-1:8];

  ipi_ctrl #(
    .NUM_CORES (NUM_CORES),
    .MBOX_WORDS(MBOX_WORDS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqCore (reqCore),
    .reqOff  (reqAddr[7:0]),
    .reqSize (reqSize),
    .reqWdata(reqWdata),
    .stb     (stb),
    .rdSel   (rdSel),
    .rdBank  (rdBank),
    .rdIdx   (rdIdx),
    .rdWord  (rdWord),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .rspRdata(rspRdata)
  );

  ipi_datapath #(
    .NUM_CORES (NUM_CORES),
    .MBOX_WORDS(MBOX_WORDS)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .rdSel (rdSel),
    .rdBank(rdBank),
    .rdIdx (rdIdx),
    .rdWord(rdWord),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/ipi_regs_checker.sv
`timescale 1ns/1ps
module ipi_regs_checker #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqWrite,
  input logic [9:0]           reqCore,
  input logic [ADDR_W-1:0]    reqAddr,
  input logic [3:0]           reqSize,
  input logic [31:0]          reqWdata,
  input logic                 rspValid,
  input logic                 rspErr,
  input logic [31:0]          rspRdata,
  input logic [NUM_CORES-1:0] irqOut
);

  localparam logic [10:0] LIM = 11'(NUM_CORES);

  logic badCore, badSend;
  assign badCore = ({1'b0, reqCore} >= LIM);
  assign badSend = reqWrite && (reqAddr[7:0] == 8'h10) && (reqSize == 4'd4)
                   && !badCore && ({1'b0, reqWdata[25:16]} >= LIM);

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R10

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R10

  AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == 32'h0)); // R10

  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != 4'd4) |=> (rspErr && $stable(irqOut))); // R1

  AST_BAD_CORE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && badCore) |=> (rspErr && $stable(irqOut))); // R3

  AST_BAD_SEND_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && badSend) |=> (rspErr && $stable(irqOut))); // R7

endmodule

bind ipi_regs_top ipi_regs_checker #(
  .NUM_CORES(NUM_CORES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqWrite(reqWrite),
  .reqCore (reqCore),
  .reqAddr (reqAddr),
  .reqSize (reqSize),
  .reqWdata(reqWdata),
  .rspValid(rspValid),
  .rspErr  (rspErr),
  .rspRdata(rspRdata),
  .irqOut  (irqOut)
);

// File: tb/test_ipi_regs_top.sv
`timescale 1ns/1ps
module test_ipi_regs_top;

  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [9:0]    reqCore = '0;
  logic [11:0]   reqAddr = '0;
  logic [3:0]    reqSize = 4'd4;
  logic [31:0]   reqWdata = '0;
  logic          rspValid, rspErr;
  logic [31:0]   rspRdata;
  logic [NC-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ipi_regs_top #(.NUM_CORES(NC), .MBOX_WORDS(8), .ADDR_W(12)) i_ipi_regs_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCore(reqCore), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspErr(rspErr),
    .rspRdata(rspRdata), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  core;
    logic [11:0] addr;
    logic [3:0]  size;
    logic [31:0] wdata;
    logic        expErr;
    logic [31:0] expData;
    logic [3:0]  expIrq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 10'd0, 12'h000, 4'd4, 32'h0,        1'b0, 32'h0,        4'h0, 8'd11}, // R11
    '{1'b1, 10'd0, 12'h004, 4'd4, 32'h000000FF, 1'b0, 32'h0,        4'h0, 8'd5},  // R5
    '{1'b1, 10'd0, 12'h008, 4'd4, 32'h00000011, 1'b0, 32'h0,        4'h1, 8'd4},  // R4
    '{1'b0, 10'd0, 12'h000, 4'd4, 32'h0,        1'b0, 32'h00000011, 4'h1, 8'd4},
    '{1'b0, 10'd0, 12'h004, 4'd4, 32'h0,        1'b0, 32'h000000FF, 4'h1, 8'd5},
    '{1'b1, 10'd0, 12'h00C, 4'd4, 32'h00000001, 1'b0, 32'h0,        4'h1, 8'd4},
    '{1'b0, 10'd0, 12'h000, 4'd4, 32'h0,        1'b0, 32'h00000010, 4'h1, 8'd4},
    '{1'b1, 10'd0, 12'h00C, 4'd4, 32'h00000010, 1'b0, 32'h0,        4'h0, 8'd5},
    '{1'b1, 10'd1, 12'h004, 4'd4, 32'h80000000, 1'b0, 32'h0,        4'h0, 8'd5},
    '{1'b1, 10'd0, 12'h010, 4'd4, 32'h0001001F, 1'b0, 32'h0,        4'h2, 8'd6},  // R6
    '{1'b0, 10'd1, 12'h000, 4'd4, 32'h0,        1'b0, 32'h80000000, 4'h2, 8'd6},
    '{1'b0, 10'd0, 12'h000, 4'd4, 32'h0,        1'b0, 32'h0,        4'h2, 8'd6},
    '{1'b1, 10'd2, 12'h010, 4'd4, 32'h00040003, 1'b1, 32'h0,        4'h2, 8'd7},  // R7
    '{1'b0, 10'd3, 12'h000, 4'd4, 32'h0,        1'b0, 32'h0,        4'h2, 8'd7},
    '{1'b1, 10'd2, 12'h010, 4'd4, 32'hFC0200E5, 1'b0, 32'h0,        4'h2, 8'd6},
    '{1'b0, 10'd2, 12'h100, 4'd4, 32'h0,        1'b0, 32'h00000020, 4'h2, 8'd2},  // R2
    '{1'b1, 10'd2, 12'h104, 4'd4, 32'h00000020, 1'b0, 32'h0,        4'h6, 8'd2},
    '{1'b1, 10'd3, 12'h020, 4'd4, 32'hDEADBEEF, 1'b0, 32'h0,        4'h6, 8'd9},  // R9
    '{1'b1, 10'd3, 12'h03C, 4'd4, 32'h12345678, 1'b0, 32'h0,        4'h6, 8'd9},
    '{1'b0, 10'd3, 12'h020, 4'd4, 32'h0,        1'b0, 32'hDEADBEEF, 4'h6, 8'd9},
    '{1'b0, 10'd3, 12'h03C, 4'd4, 32'h0,        1'b0, 32'h12345678, 4'h6, 8'd9},
    '{1'b0, 10'd0, 12'h020, 4'd4, 32'h0,        1'b0, 32'h0,        4'h6, 8'd3},  // R3
    '{1'b1, 10'd3, 12'h004, 4'd2, 32'hFFFFFFFF, 1'b1, 32'h0,        4'h6, 8'd1},  // R1
    '{1'b0, 10'd3, 12'h004, 4'd4, 32'h0,        1'b0, 32'h0,        4'h6, 8'd1},
    '{1'b1, 10'd3, 12'h008, 4'd8, 32'h00000001, 1'b1, 32'h0,        4'h6, 8'd1},
    '{1'b0, 10'd3, 12'h000, 4'd4, 32'h0,        1'b0, 32'h0,        4'h6, 8'd1},
    '{1'b1, 10'd3, 12'h040, 4'd4, 32'hFFFFFFFF, 1'b0, 32'h0,        4'h6, 8'd8},  // R8
    '{1'b0, 10'd3, 12'h040, 4'd4, 32'h0,        1'b0, 32'h0,        4'h6, 8'd8},
    '{1'b0, 10'd3, 12'h008, 4'd4, 32'h0,        1'b0, 32'h0,        4'h6, 8'd8},
    '{1'b0, 10'd5, 12'h000, 4'd4, 32'h0,        1'b1, 32'h0,        4'h6, 8'd3},
    '{1'b1, 10'd7, 12'h004, 4'd4, 32'hFFFFFFFF, 1'b1, 32'h0,        4'h6, 8'd3},
    '{1'b1, 10'd1, 12'h00C, 4'd4, 32'hFFFFFFFF, 1'b0, 32'h0,        4'h4, 8'd4},
    '{1'b0, 10'd2, 12'hF00, 4'd4, 32'h0,        1'b0, 32'h00000020, 4'h4, 8'd2},
    '{1'b1, 10'd3, 12'h022, 4'd4, 32'h55555555, 1'b0, 32'h0,        4'h4, 8'd8},
    '{1'b0, 10'd3, 12'h020, 4'd4, 32'h0,        1'b0, 32'hDEADBEEF, 4'h4, 8'd8}
  };

  task automatic check(input int r, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  // Drive at a falling edge, sample the registered response one cycle later
  task automatic doReq(input logic wr, input logic [9:0] core,
                       input logic [11:0] addr, input logic [3:0] size,
                       input logic [31:0] wdata);
    reqValid = 1'b1;
    reqWrite = wr;
    reqCore  = core;
    reqAddr  = addr;
    reqSize  = size;
    reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state at the ports
    check(11, "irq after reset", 32'(irqOut), 32'h0);
    check(10, "no response when idle", 32'(rspValid), 32'h0);

    for (int i = 0; i < NV; i++) begin
      doReq(TBL[i].wr, TBL[i].core, TBL[i].addr, TBL[i].size, TBL[i].wdata);
      check(10, $sformatf("vec %0d rspValid", i), 32'(rspValid), 32'h1);
      check(int'(TBL[i].req), $sformatf("vec %0d rspErr", i), 32'(rspErr),
            32'(TBL[i].expErr));
      check(int'(TBL[i].req), $sformatf("vec %0d rdata", i), rspRdata,
            TBL[i].expData);
      check(int'(TBL[i].req), $sformatf("vec %0d irq", i), 32'(irqOut),
            32'(TBL[i].expIrq));
    end

    // R10: idle cycle gives no response
    @(negedge clk);
    check(10, "idle after table", 32'(rspValid), 32'h0);

    // R11: reset clears populated state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(11, "irq cleared by reset", 32'(irqOut), 32'h0);
    doReq(1'b0, 10'd2, 12'h000, 4'd4, 32'h0);
    check(11, "status c2 after reset", rspRdata, 32'h0);
    doReq(1'b0, 10'd0, 12'h004, 4'd4, 32'h0);
    check(11, "enable c0 after reset", rspRdata, 32'h0);
    doReq(1'b0, 10'd3, 12'h020, 4'd4, 32'h0);
    check(11, "mailbox c3 after reset", rspRdata, 32'h0);

    // R6: send to self with vector 0 sets own status bit 0
    doReq(1'b1, 10'd3, 12'h004, 4'd4, 32'h00000001);
    doReq(1'b1, 10'd3, 12'h010, 4'd4, 32'h00030000);
    check(6, "self send irq", 32'(irqOut), 32'h8);

    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule